// File: doc/BRIEF.md
# eMMC Block-Write Response and Busy Monitor

This block follows the DAT0 line while a host writes blocks to an eMMC device. Each block goes through three guarded phases. First the block waits until the write FIFO holds a full block; only then may the data path drive it. Once the data path reports that the block's data and CRC are out, the block waits for the device's CRC status frame, collects its three status bits and checks the closing stop bit. Last, it times the busy period during which the device pulls DAT0 low. All three phases are bounded by the same programmable data timeout, counted in card-clock sample enables, and each phase has its own error flag.

A transfer is launched either as a single block or as a multi-block run of a programmed length. In a multi-block run the three phases repeat once per block, and the run stops at the first error. Results are kept in two banks of sticky flags, one bank per mode. Each bank is cleared by its own clear pulse. A live busy output reflects the last sampled level of DAT0.

Top module: `emmc_wr_resp_mon`

## Requirements
- R1: In the fill phase, `blk_go` goes high on the clock after `fifo_level >= blk_len` is seen, and stays high until `blk_sent`. If the FIFO is still short on the (`tmo_val`+1)-th sample enable of the phase, flag bit 4 (FIFO timeout) is set, `blk_go` never rises and the transfer ends.
- R2: After `blk_sent`, DAT0 high on `tmo_val`+1 consecutive sample enables, with no start bit, sets flag bit 2 (status frame error). A start bit on the `tmo_val`-th or an earlier sample enable is accepted.
- R3: If the sample after the three status bits (the stop bit) reads DAT0 low, flag bit 2 is set and the transfer ends.
- R4: The three status bits are shifted into `crc_stat`, first bit received in bit 2. `crc_stat` changes only on sample enables. Any value other than 3'b010 with a valid stop bit sets flag bit 1 (CRC error) and ends the transfer.
- R5: In the busy phase, DAT0 low on `tmo_val`+1 consecutive sample enables sets flag bit 3 (busy timeout). DAT0 high on a sample after `tmo_val` or fewer low samples ends the block normally.
- R6: `busy_live` is the inverse of DAT0 as captured on the latest sample enable. It is 0 after reset.
- R7: Flag bit 0 (done) is set when the last block of a transfer completes without error. Single-block results go to `sb_flags` and multi-block results to `mb_flags`. A multi-block run performs `blk_cnt` blocks, and a count of 0 performs one block. The run aborts at the first error, and then only that error's bit is set.
- R8: DAT0 is sampled only on `samp_en`. Changes of DAT0 between sample enables have no effect on the result.
- R9: Flags stay set until a pulse on that bank's clear (`clr_sb` or `clr_mb`). A clear affects only its own bank.
- R10: Start requests are ignored while a transfer is active. When `start_single` and `start_multi` arrive together, the single-block mode wins.
- R11: After reset, `blk_go`, `busy_live`, `crc_stat`, `sb_flags` and `mb_flags` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Card-clock sample enable; DAT0 is sampled and timeouts count on it |
| dat0 | input | 1 | DAT0 line level |
| fifo_level | input | LVL_W | Bytes currently in the write FIFO |
| blk_len | input | LVL_W | Block length in bytes |
| blk_cnt | input | CNT_W | Block count for a multi-block run |
| tmo_val | input | TMO_W | Data timeout in sample enables |
| start_single | input | 1 | Pulse: begin a single-block write |
| start_multi | input | 1 | Pulse: begin a multi-block write |
| blk_sent | input | 1 | Pulse: block data and CRC have been driven |
| clr_sb | input | 1 | Pulse: clear single-block flags |
| clr_mb | input | 1 | Pulse: clear multi-block flags |
| blk_go | output | 1 | FIFO holds a full block; data path may send |
| busy_live | output | 1 | Device holding DAT0 low at last sample |
| crc_stat | output | 3 | Last captured CRC status bits |
| sb_flags | output | 5 | Single-block flags {fifo_to, busy_to, frame_err, crc_err, done} |
| mb_flags | output | 5 | Multi-block flags, same layout |

## Verification
The bench probes every timeout at both sides of its boundary: exactly `tmo_val` unmet samples must pass, and one more must fail. An off-by-one counter or a missed reload at phase entry would move the flag by one sample or carry a stale count into the next phase. Other tests use a low stop bit, a bad status pattern that must show up in `crc_stat`, and a zero timeout. They would expose a design that checks the pattern before the stop bit, or that shifts the status bits in the wrong order. Multi-block runs cover a clean three-block run, an abort in the second block and a zero count; a design that ignored the abort or routed the result to the wrong bank would raise the wrong flags. One block takes a stray start pulse and DAT0 glitches between sample enables; a design that sampled DAT0 on every clock, or restarted on the stray pulse, would end with a status frame error or the wrong bank.

// File: rtl/wrmon_pkg.sv
package wrmon_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_SEND,
    ST_SWAIT,
    ST_SBITS,
    ST_SSTOP,
    ST_BUSY
  } wr_state_e;

  // flag bank bit positions
  localparam int FLG_DONE   = 0;
  localparam int FLG_CRC    = 1;
  localparam int FLG_FRAME  = 2;
  localparam int FLG_BUSYTO = 3;
  localparam int FLG_FIFOTO = 4;
  localparam int FLG_N      = 5;

  localparam logic [2:0] STAT_GOOD = 3'b010;

endpackage

// File: rtl/wrmon_timer.sv
module wrmon_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         tick,
  input  logic [W-1:0] value,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = value;
    else if (tick && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/wrmon_frame.sv
module wrmon_frame #(
  parameter int NBITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift,
  input  logic             bit_in,
  output logic [NBITS-1:0] stat
);

  logic [NBITS-1:0] stat_q, stat_d;

  always_comb begin
    stat_d = stat_q;
    if (shift) stat_d = {stat_q[NBITS-2:0], bit_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;

endmodule

// File: rtl/wrmon_flags.sv
module wrmon_flags #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flags
);

  logic [N-1:0] flg_q, flg_d;

  // a new event in the clear cycle survives the clear
  always_comb begin
    if (clr) flg_d = set;
    else     flg_d = flg_q | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flags = flg_q;

endmodule

// File: rtl/emmc_wr_resp_mon.sv
module emmc_wr_resp_mon
  import wrmon_pkg::*;
#(
  parameter int LVL_W = 12,
  parameter int CNT_W = 8,
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_en,
  input  logic             dat0,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] blk_len,
  input  logic [CNT_W-1:0] blk_cnt,
  input  logic [TMO_W-1:0] tmo_val,
  input  logic             start_single,
  input  logic             start_multi,
  input  logic             blk_sent,
  input  logic             clr_sb,
  input  logic             clr_mb,
  output logic             blk_go,
  output logic             busy_live,
  output logic [2:0]       crc_stat,
  output logic [FLG_N-1:0] sb_flags,
  output logic [FLG_N-1:0] mb_flags
);

  localparam int NBANK = 2;
  localparam int STATW = 3;

  wr_state_e        state_q, state_d;
  logic             mode_q, mode_d;        // 1: multi-block run
  logic [CNT_W-1:0] left_q, left_d;
  logic [1:0]       bit_q, bit_d;
  logic             dat0_q;
  logic             tmo_exp, tmo_load, shift;
  logic [FLG_N-1:0] evt;
  logic [STATW-1:0] stat;
  logic [FLG_N-1:0] set_v [NBANK];
  logic [FLG_N-1:0] flg_v [NBANK];
  logic             clr_v [NBANK];

  // next-state process
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    left_d  = left_q;
    bit_d   = bit_q;
    shift   = 1'b0;
    evt     = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_single) begin
          state_d = ST_FILL;
          mode_d  = 1'b0;
          left_d  = CNT_W'(1);
        end else if (start_multi) begin
          state_d = ST_FILL;
          mode_d  = 1'b1;
          left_d  = blk_cnt;
        end
      end
      ST_FILL: begin
        if (fifo_level >= blk_len) begin
          state_d = ST_SEND;
        end else if (samp_en && tmo_exp) begin
          evt[FLG_FIFOTO] = 1'b1;
          state_d         = ST_IDLE;
        end
      end
      ST_SEND: begin
        if (blk_sent) state_d = ST_SWAIT;
      end
      ST_SWAIT: begin
        if (samp_en) begin
          if (!dat0) begin
            state_d = ST_SBITS;
            bit_d   = '0;
          end else if (tmo_exp) begin
            evt[FLG_FRAME] = 1'b1;
            state_d        = ST_IDLE;
          end
        end
      end
      ST_SBITS: begin
        if (samp_en) begin
          shift = 1'b1;
          if (bit_q == 2'(STATW - 1)) state_d = ST_SSTOP;
          else                        bit_d   = bit_q + 1'b1;
        end
      end
      ST_SSTOP: begin
        if (samp_en) begin
          if (!dat0) begin
            evt[FLG_FRAME] = 1'b1;
            state_d        = ST_IDLE;
          end else if (stat != STAT_GOOD) begin
            evt[FLG_CRC] = 1'b1;
            state_d      = ST_IDLE;
          end else begin
            state_d = ST_BUSY;
          end
        end
      end
      ST_BUSY: begin
        if (samp_en) begin
          if (dat0) begin
            if (left_q <= CNT_W'(1)) begin
              evt[FLG_DONE] = 1'b1;
              state_d       = ST_IDLE;
            end else begin
              left_d  = left_q - 1'b1;
              state_d = ST_FILL;
            end
          end else if (tmo_exp) begin
            evt[FLG_BUSYTO] = 1'b1;
            state_d         = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // every phase entry reloads the shared timeout
  assign tmo_load = (state_d != state_q);

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= 1'b0;
      left_q  <= '0;
      bit_q   <= '0;
      dat0_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      left_q  <= left_d;
      bit_q   <= bit_d;
      if (samp_en) dat0_q <= dat0;
    end
  end

  wrmon_timer #(.W(TMO_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmo_load),
    .tick    (samp_en),
    .value   (tmo_val),
    .expired (tmo_exp)
  );

  wrmon_frame #(.NBITS(STATW)) u_frame (
    .clk    (clk),
    .rst_n  (rst_n),
    .shift  (shift),
    .bit_in (dat0),
    .stat   (stat)
  );

  assign clr_v[0] = clr_sb;
  assign clr_v[1] = clr_mb;

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign set_v[g] = (mode_q == (g != 0)) ? evt : '0;
    wrmon_flags #(.N(FLG_N)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_v[g]),
      .set   (set_v[g]),
      .flags (flg_v[g])
    );
  end

  assign sb_flags  = flg_v[0];
  assign mb_flags  = flg_v[1];
  assign blk_go    = (state_q == ST_SEND);
  assign busy_live = ~dat0_q;
  assign crc_stat  = stat;

endmodule

// File: rtl/emmc_wr_resp_mon_sva.sv
module emmc_wr_resp_mon_sva #(
  parameter int LVL_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             samp_en,
  input logic [LVL_W-1:0] fifo_level,
  input logic [LVL_W-1:0] blk_len,
  input logic             clr_sb,
  input logic             clr_mb,
  input logic             blk_go,
  input logic             busy_live,
  input logic [2:0]       crc_stat,
  input logic [4:0]       sb_flags,
  input logic [4:0]       mb_flags
);

  a_r1_go_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_go) |-> $past(fifo_level >= blk_len));

  a_r4_stat_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> $stable(crc_stat));

  a_r6_live_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> $stable(busy_live));

  a_r5_busy_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sb_flags[3]) || $rose(mb_flags[3])) |-> busy_live);

  a_r9_sb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_sb |=> ((sb_flags & $past(sb_flags)) == $past(sb_flags)));

  a_r9_mb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_mb |=> ((mb_flags & $past(mb_flags)) == $past(mb_flags)));

  a_r7_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !((|(sb_flags & ~$past(sb_flags))) && (|(mb_flags & ~$past(mb_flags)))));

endmodule

bind emmc_wr_resp_mon emmc_wr_resp_mon_sva #(.LVL_W(LVL_W)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .samp_en    (samp_en),
  .fifo_level (fifo_level),
  .blk_len    (blk_len),
  .clr_sb     (clr_sb),
  .clr_mb     (clr_mb),
  .blk_go     (blk_go),
  .busy_live  (busy_live),
  .crc_stat   (crc_stat),
  .sb_flags   (sb_flags),
  .mb_flags   (mb_flags)
);

// File: tb/tb_emmc_wr_resp_mon.sv
`timescale 1ns/1ps
module tb_emmc_wr_resp_mon;

  localparam int LVL_W = 12;
  localparam int CNT_W = 8;
  localparam int TMO_W = 16;
  localparam int BL    = 512;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             samp_en = 1'b0;
  logic             dat0 = 1'b1;
  logic [LVL_W-1:0] fifo_level = '0;
  logic [LVL_W-1:0] blk_len = LVL_W'(BL);
  logic [CNT_W-1:0] blk_cnt = '0;
  logic [TMO_W-1:0] tmo_val = TMO_W'(3);
  logic             start_single = 1'b0;
  logic             start_multi = 1'b0;
  logic             blk_sent = 1'b0;
  logic             clr_sb = 1'b0;
  logic             clr_mb = 1'b0;
  logic             blk_go, busy_live;
  logic [2:0]       crc_stat;
  logic [4:0]       sb_flags, mb_flags;

  always #2.5 clk = ~clk;

  emmc_wr_resp_mon #(.LVL_W(LVL_W), .CNT_W(CNT_W), .TMO_W(TMO_W)) dut (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .dat0(dat0),
    .fifo_level(fifo_level), .blk_len(blk_len), .blk_cnt(blk_cnt),
    .tmo_val(tmo_val), .start_single(start_single), .start_multi(start_multi),
    .blk_sent(blk_sent), .clr_sb(clr_sb), .clr_mb(clr_mb),
    .blk_go(blk_go), .busy_live(busy_live), .crc_stat(crc_stat),
    .sb_flags(sb_flags), .mb_flags(mb_flags)
  );

  typedef struct {
    logic [4:0] sb;
    logic [4:0] mb;
    bit         chk_stat;
    logic [2:0] stat;
    string      req;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_fail = 0;

  task automatic check(string req, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // outcome codes: 0 ok, 1 fifo timeout, 2 frame error, 3 crc error, 4 busy timeout
  function automatic logic [4:0] code2flag(int c);
    case (c)
      0: return 5'b00001;
      1: return 5'b10000;
      2: return 5'b00100;
      3: return 5'b00010;
      default: return 5'b01000;
    endcase
  endfunction

  function automatic int predict(int pre, int sdly, logic [2:0] bits, logic stop, int blen);
    int t = int'(tmo_val);
    if (pre > t)            return 1;
    if (sdly > t)           return 2;
    if (!stop)              return 2;
    if (bits != 3'b010)     return 3;
    if (blen > t)           return 4;
    return 0;
  endfunction

  task automatic push_exp(bit multi, int code, bit chk, logic [2:0] st, string req);
    exp_t e;
    e.sb = multi ? 5'b0 : code2flag(code);
    e.mb = multi ? code2flag(code) : 5'b0;
    e.chk_stat = chk;
    e.stat = st;
    e.req = req;
    q.push_back(e);
  endtask

  task automatic tick(input logic v);
    @(negedge clk);
    dat0 = v;
    samp_en = 1'b1;
    @(negedge clk);
    samp_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic start(bit s, bit m, int cnt);
    @(negedge clk);
    dat0 = 1'b1;
    blk_cnt = CNT_W'(cnt);
    start_single = s;
    start_multi = m;
    @(negedge clk);
    start_single = 1'b0;
    start_multi = 1'b0;
  endtask

  // drives one block; poke adds a stray start pulse and DAT0 glitches between samples
  task automatic block(int pre, int sdly, logic [2:0] bits, logic stop, int blen, bit poke);
    int t = int'(tmo_val);
    if (pre > t) begin
      for (int i = 0; i <= t; i++) tick(1'b1);
      check("R1", int'(blk_go), 0, "blk_go after fifo timeout");
      return;
    end
    for (int i = 0; i < pre; i++) tick(1'b1);
    @(negedge clk);
    fifo_level = LVL_W'(BL);
    @(negedge clk);
    check("R1", int'(blk_go), 1, "blk_go once fifo holds a block");
    blk_sent = 1'b1;
    fifo_level = '0;
    @(negedge clk);
    blk_sent = 1'b0;
    if (poke) begin
      start_single = 1'b1;
      dat0 = 1'b0;
      @(negedge clk);
      start_single = 1'b0;
      @(negedge clk);
      @(negedge clk);
      dat0 = 1'b1;
    end
    if (sdly > t) begin
      for (int i = 0; i <= t; i++) tick(1'b1);
      return;
    end
    for (int i = 0; i < sdly; i++) tick(1'b1);
    tick(1'b0);
    tick(bits[2]);
    tick(bits[1]);
    tick(bits[0]);
    tick(stop);
    if (!stop || bits != 3'b010) return;
    if (blen > t) begin
      for (int i = 0; i <= t; i++) tick(1'b0);
      return;
    end
    for (int i = 0; i < blen; i++) tick(1'b0);
    if (blen > 0) check("R6", int'(busy_live), 1, "busy_live during busy");
    tick(1'b1);
    check("R6", int'(busy_live), 0, "busy_live after busy release");
  endtask

  task automatic drain();
    wait (q.size() == 0 && sb_flags == '0 && mb_flags == '0);
    repeat (4) @(negedge clk);
  endtask

  task automatic single_case(int pre, int sdly, logic [2:0] bits, logic stop, int blen,
                             bit chk, string req);
    push_exp(1'b0, predict(pre, sdly, bits, stop, blen), chk, bits, req);
    start(1'b1, 1'b0, 0);
    block(pre, sdly, bits, stop, blen, 1'b0);
    drain();
  endtask

  // monitor: pops the expected result when a flag bank reports, then clears it
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (sb_flags != '0 || mb_flags != '0)) begin
        logic [4:0] seen_sb, seen_mb;
        seen_sb = sb_flags;
        seen_mb = mb_flags;
        if (q.size() == 0) begin
          check("R7", int'({seen_mb, seen_sb}), 0, "unexpected flags");
        end else begin
          exp_t e;
          e = q.pop_front();
          check(e.req, int'(seen_sb), int'(e.sb), "sb_flags");
          check(e.req, int'(seen_mb), int'(e.mb), "mb_flags");
          if (e.chk_stat) check("R4", int'(crc_stat), int'(e.stat), "crc_stat");
        end
        repeat (3) @(negedge clk);
        check("R9", int'({mb_flags, sb_flags}), int'({seen_mb, seen_sb}), "flags held");
        clr_sb = (seen_sb != '0);
        clr_mb = (seen_mb != '0);
        @(negedge clk);
        clr_sb = 1'b0;
        clr_mb = 1'b0;
        check("R9", int'({mb_flags, sb_flags}), 0, "flags after clear");
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", int'({blk_go, busy_live, crc_stat, sb_flags, mb_flags}), 0, "reset state");

    // single-block cases, timeout 3
    single_case(2, 1, 3'b010, 1'b1, 2, 1'b1, "R7");
    single_case(3, 0, 3'b010, 1'b1, 0, 1'b0, "R1");
    single_case(4, 0, 3'b010, 1'b1, 0, 1'b0, "R1");
    single_case(0, 3, 3'b010, 1'b1, 1, 1'b0, "R2");
    single_case(0, 4, 3'b010, 1'b1, 1, 1'b0, "R2");
    single_case(0, 1, 3'b010, 1'b0, 1, 1'b1, "R3");
    single_case(1, 1, 3'b110, 1'b1, 1, 1'b1, "R4");
    single_case(0, 2, 3'b011, 1'b1, 1, 1'b1, "R4");
    single_case(0, 0, 3'b010, 1'b1, 3, 1'b0, "R5");
    single_case(0, 0, 3'b010, 1'b1, 4, 1'b0, "R5");

    // multi-block: three clean blocks, stray start and glitches on the second (R8, R10)
    push_exp(1'b1, 0, 1'b1, 3'b010, "R8");
    start(1'b0, 1'b1, 3);
    block(1, 1, 3'b010, 1'b1, 2, 1'b0);
    block(0, 2, 3'b010, 1'b1, 1, 1'b1);
    block(2, 0, 3'b010, 1'b1, 3, 1'b0);
    drain();

    // multi-block abort at the second block on busy timeout
    push_exp(1'b1, 4, 1'b0, 3'b010, "R7");
    start(1'b0, 1'b1, 3);
    block(0, 1, 3'b010, 1'b1, 1, 1'b0);
    block(0, 1, 3'b010, 1'b1, 4, 1'b0);
    drain();

    // multi-block with a count of zero runs one block
    push_exp(1'b1, 0, 1'b0, 3'b010, "R7");
    start(1'b0, 1'b1, 0);
    block(0, 0, 3'b010, 1'b1, 0, 1'b0);
    drain();

    // both starts together: single wins
    push_exp(1'b0, 0, 1'b0, 3'b010, "R10");
    start(1'b1, 1'b1, 4);
    block(0, 0, 3'b010, 1'b1, 1, 1'b0);
    drain();

    // zero timeout: one low busy sample is already too long
    tmo_val = '0;
    single_case(0, 0, 3'b010, 1'b1, 1, 1'b0, "R5");
    single_case(0, 0, 3'b010, 1'b1, 0, 1'b0, "R7");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule